// File: doc/BRIEF.md
# Programmable Periodic-Rate Square-Wave Generator

This block takes a strobe that fires once per period of a 32768 Hz reference and derives slower binary-submultiple rates from it. A free-running prescaler counts the strobes. A 4-bit rate code chooses one prescaler bit. That bit drives a square-wave pin and produces a one-cycle periodic-event pulse, which an interrupt-flag register elsewhere can capture.

The rate map is not linear. Code 0 stops the block: the pin stays static and no events are produced. Codes 3 to 15 divide the reference down from 8192 Hz to 2 Hz. Codes 1 and 2 are aliases of codes 8 and 9. A full-rate override bit places the undivided reference on the pin and suppresses all periodic events. Everything runs in one synchronous clock domain. The reference appears only as an enable strobe.

Top module: `sqw_rate_gen`

## Requirements
- R1: After reset the pin and the event pulse are low and the prescaler count is zero. The first reference strobe after reset brings the count to 1.
- R2: With the override clear and code 0, the pin is held low and no event pulse occurs.
- R3: For a code c from 3 to 15, with the override clear and the pin enable set, the pin equals bit (c-2) of the prescaler count. This gives a period of 2^(c-1) strobes (code 3: 8192 Hz, code 15: 2 Hz). The pin is registered and follows the count one clock after the strobe edge.
- R4: Code 1 behaves exactly like code 8 (prescaler bit 6), and code 2 behaves exactly like code 9 (prescaler bit 7).
- R5: With the override clear and the pin enable low, the pin is held low. Event pulses continue as selected by the code.
- R6: With the override set, the pin carries the registered reference strobe, whatever the code and the pin enable. No event pulse occurs.
- R7: For a nonzero code with the override clear, the event pulse is high for exactly one clock after each strobe that takes the selected prescaler bit from 0 to 1. It never lasts two clocks.
- R8: A change of rate code does not reset the prescaler. A change that merely exposes a bit that is already high produces no event pulse.
- R9: In a clock without a strobe the count holds, no event pulse occurs, and the pin (without override) keeps its value.
- R10: The 15-bit prescaler wraps from all ones to zero, and the bit selected by code 15 keeps its 2^14-strobe period across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-clock strobe, once per 32768 Hz reference period |
| rate_code | input | 4 | Rate-select code |
| sqw_en | input | 1 | Enables the divided square wave on the pin |
| full_rate | input | 1 | Override: reference on the pin, events suppressed |
| sqw_out | output | 1 | Square-wave pin |
| periodic_pulse | output | 1 | One-clock periodic-event pulse |

## Verification
The hardest situation to reach is the slowest rate carried across a prescaler wrap. It needs more than 32768 consecutive strobes at code 15, with no rate change to hide a missed or extra event. A directed run applies a strobe on every clock at code 15 for long enough to pass the wrap. Constrained-random segments then change the code, the enable and the override in the middle of a count. This catches spurious events when a newly selected bit is already high, and checks that ticks missing between strobes hold every output.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

   localparam int unsigned RATE_CODE_W = 4;
   localparam int unsigned TAP_IDX_W   = 4;

   // Decoded rate selection: which prescaler bit, and whether any.
   typedef struct packed {
      logic                 active;
      logic [TAP_IDX_W-1:0] idx;
   } tap_sel_t;

   // Maps a rate code to a prescaler bit. Code 0 means stopped; the two
   // lowest nonzero codes alias onto the 256 Hz and 128 Hz taps.
   function automatic tap_sel_t rate_to_tap(input logic [RATE_CODE_W-1:0] code);
      tap_sel_t t;
      unique case (code)
         4'd0: begin t.active = 1'b0; t.idx = '0;    end
         4'd1: begin t.active = 1'b1; t.idx = 4'd6;  end
         4'd2: begin t.active = 1'b1; t.idx = 4'd7;  end
         default: begin
            t.active = 1'b1;
            t.idx    = code - 4'd2;
         end
      endcase
      return t;
   endfunction

endpackage

// File: rtl/sqw_prescaler.sv
module sqw_prescaler #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_nx
);

   if (CNT_W < 2) begin : g_bad_width
      $error("sqw_prescaler: CNT_W must be at least 2");
   end

   assign count_nx = tick ? count_q + 1'b1 : count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_nx;
   end

endmodule

// File: rtl/sqw_rate_decode.sv
module sqw_rate_decode
   import sqw_pkg::*;
#(
   parameter int unsigned CNT_W = 15
) (
   input  logic [RATE_CODE_W-1:0] rate_code,
   output logic [CNT_W-1:0]       tap_oh
);

   localparam int unsigned MAX_TAP = 13;

   if (CNT_W <= MAX_TAP) begin : g_bad_width
      $error("sqw_rate_decode: CNT_W too small for the slowest rate");
   end

   tap_sel_t sel;
   assign sel = rate_to_tap(rate_code);

   for (genvar i = 0; i < CNT_W; i++) begin : g_tap
      if (i <= MAX_TAP) begin : g_used
         assign tap_oh[i] = sel.active && (sel.idx == TAP_IDX_W'(i));
      end else begin : g_unused
         assign tap_oh[i] = 1'b0;
      end
   end

endmodule

// File: rtl/sqw_tap_select.sv
module sqw_tap_select #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             tick,
   input  logic [CNT_W-1:0] count_nx,
   input  logic [CNT_W-1:0] tap_oh,
   output logic             level,
   output logic             rise
);

   // rise_vec[i]: bit i of the next count has just turned 1, i.e. the low
   // bits below it are all zero and bit i is set.
   logic [CNT_W-1:0] rise_vec;

   for (genvar i = 0; i < CNT_W; i++) begin : g_rise
      if (i == 0) begin : g_lsb
         assign rise_vec[i] = count_nx[0];
      end else begin : g_upper
         assign rise_vec[i] = count_nx[i] && (count_nx[i-1:0] == '0);
      end
   end

   assign level = |(count_nx & tap_oh);
   assign rise  = tick && |(rise_vec & tap_oh);

endmodule

// File: rtl/sqw_rate_gen.sv
module sqw_rate_gen
   import sqw_pkg::*;
#(
   parameter int unsigned CNT_W  = 15,
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [CODE_W-1:0] rate_code,
   input  logic              sqw_en,
   input  logic              full_rate,
   output logic              sqw_out,
   output logic              periodic_pulse
);

   if (CODE_W != RATE_CODE_W) begin : g_bad_code
      $error("sqw_rate_gen: CODE_W must equal the packaged rate code width");
   end

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_nx;
   logic [CNT_W-1:0] tap_oh;
   logic             tap_level;
   logic             tap_rise;
   logic             sqw_q;
   logic             pulse_q;

   sqw_prescaler #(.CNT_W(CNT_W)) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (ref_tick),
      .count_q  (count_q),
      .count_nx (count_nx)
   );

   sqw_rate_decode #(.CNT_W(CNT_W)) u_dec (
      .rate_code (rate_code),
      .tap_oh    (tap_oh)
   );

   sqw_tap_select #(.CNT_W(CNT_W)) u_sel (
      .tick     (ref_tick),
      .count_nx (count_nx),
      .tap_oh   (tap_oh),
      .level    (tap_level),
      .rise     (tap_rise)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sqw_q   <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         sqw_q   <= full_rate ? ref_tick : (sqw_en & tap_level);
         pulse_q <= ~full_rate & tap_rise;
      end
   end

   assign sqw_out        = sqw_q;
   assign periodic_pulse = pulse_q;

endmodule

// File: rtl/sqw_rate_gen_chk.sv
module sqw_rate_gen_chk #(
   parameter int unsigned CNT_W  = 15,
   parameter int unsigned CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic [CODE_W-1:0] rate_code,
   input logic              sqw_en,
   input logic              full_rate,
   input logic              sqw_out,
   input logic              periodic_pulse,
   input logic [CNT_W-1:0]  count_q
);

   a_r2_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_code == '0 && !full_rate) |=> (!sqw_out && !periodic_pulse));

   a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!sqw_en && !full_rate) |=> !sqw_out);

   a_r6_override_follows: assert property (@(posedge clk) disable iff (!rst_n)
      full_rate |=> (!periodic_pulse && sqw_out == $past(ref_tick)));

   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      periodic_pulse |=> !periodic_pulse);

   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> ($stable(count_q) && !periodic_pulse));

   a_r9_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_tick && !full_rate && $stable(rate_code) && $stable(sqw_en)
       && !$past(full_rate)) |=> $stable(sqw_out));

endmodule

bind sqw_rate_gen sqw_rate_gen_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ref_tick       (ref_tick),
   .rate_code      (rate_code),
   .sqw_en         (sqw_en),
   .full_rate      (full_rate),
   .sqw_out        (sqw_out),
   .periodic_pulse (periodic_pulse),
   .count_q        (count_q)
);

// File: tb/sim_sqw_rate_gen.sv
`timescale 1ns/1ps
module sim_sqw_rate_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b0;
   logic [3:0] rate_code = 4'd0;
   logic       sqw_en = 1'b0;
   logic       full_rate = 1'b0;
   logic       sqw_out;
   logic       periodic_pulse;

   int         n_checks = 0;
   int         n_fails  = 0;
   bit         finished = 1'b0;
   logic [14:0] m = '0;
   string      tag = "";

   always #4 clk = ~clk;

   sqw_rate_gen u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .ref_tick       (ref_tick),
      .rate_code      (rate_code),
      .sqw_en         (sqw_en),
      .full_rate      (full_rate),
      .sqw_out        (sqw_out),
      .periodic_pulse (periodic_pulse)
   );

   function automatic int tap_of(input logic [3:0] c);
      if (c == 4'd1) return 6;
      if (c == 4'd2) return 7;
      return int'(c) - 2;
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0b expected %0b (code %0d count %0d)",
                  req, what, act, exp, rate_code, m);
      end
   endtask

   // Called at a falling edge: drive inputs, model the next rising edge,
   // then compare at the following falling edge.
   task automatic step(input bit t, input logic [3:0] c, input bit e, input bit f);
      int  k;
      bit  es;
      bit  ep;
      string rs;
      string rp;
      ref_tick = t; rate_code = c; sqw_en = e; full_rate = f;
      if (t) m = m + 15'd1;
      k  = tap_of(c);
      if (f)                      es = t;
      else if (e && c != 4'd0)    es = m[k];
      else                        es = 1'b0;
      ep = !f && c != 4'd0 && t && ((int'(m) & ((2 << k) - 1)) == (1 << k));
      if (tag != "")                 begin rs = tag;  rp = tag;  end
      else if (f)                    begin rs = "R6"; rp = "R6"; end
      else if (c == 4'd0)            begin rs = "R2"; rp = "R2"; end
      else if (c == 4'd1 || c == 4'd2) begin rs = "R4"; rp = "R4"; end
      else if (!e)                   begin rs = "R5"; rp = "R7"; end
      else                           begin rs = "R3"; rp = "R7"; end
      @(negedge clk);
      check(rs, sqw_out, es, "pin");
      check(rp, periodic_pulse, ep, "event");
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1", sqw_out, 1'b0, "pin after reset");
      check("R1", periodic_pulse, 1'b0, "event after reset");
      rst_n = 1'b1;

      // R1 / R3: fastest rate from a zero count
      tag = "R1";
      for (int i = 0; i < 4; i++) step(1, 4'd3, 1, 0);
      tag = "";
      for (int i = 0; i < 40; i++) step(1, 4'd3, 1, 0);

      // R2: stopped with ticks running
      for (int i = 0; i < 300; i++) step(1, 4'd0, 1, 0);

      // R4: aliases, with R5 pin disabled while events run
      for (int i = 0; i < 600; i++) step(1, 4'd1, 1, 0);
      for (int i = 0; i < 600; i++) step(1, 4'd2, 0, 0);
      for (int i = 0; i < 300; i++) step(1, 4'd8, 1, 0);

      // R6: override ignores code and enable
      for (int i = 0; i < 60; i++) step(i % 3 != 0, 4'(i), i % 2, 1);

      // R8: switch codes mid-count, including onto an already-high bit
      tag = "R8";
      for (int i = 0; i < 3; i++) step(1, 4'd4, 1, 0);
      for (int c = 3; c <= 15; c++) begin
         for (int i = 0; i < 5; i++) step(1, 4'(c), 1, 0);
      end
      tag = "";

      // R9: idle clocks with no strobe
      tag = "R9";
      for (int i = 0; i < 50; i++) step(0, 4'd5, 1, 0);
      for (int i = 0; i < 20; i++) step(i % 4 == 0, 4'd3, 1, 0);
      tag = "";

      // R10: slowest rate carried across the wrap
      tag = "R10";
      for (int i = 0; i < 33500; i++) step(1, 4'd15, 1, 0);
      tag = "";

      // Constrained random segments
      for (int s = 0; s < 400; s++) begin
         int          len;
         logic [3:0]  c;
         bit          e;
         bit          f;
         len = int'($urandom_range(20, 200));
         c   = 4'($urandom_range(0, 15));
         e   = ($urandom_range(0, 3) != 0);
         f   = ($urandom_range(0, 9) == 0);
         for (int i = 0; i < len; i++) step($urandom_range(0, 7) != 0, c, e, f);
      end

      finish_run();
   end

endmodule